// File: doc/BRIEF.md
# Double-Buffered Oversampling Serial Receiver

This block turns a start-stop asynchronous serial line into bytes. It is given a sample enable, `sample_tick`, that pulses at sixteen times the bit rate. The line rests at logic 1. Each character starts with one 0 bit, carries eight data bits with the least significant bit first, and ends with one or two 1 bits.

The input first passes through a two-stage synchronizer. Each sample enable then compares the synchronized line with its value at the previous enable. A falling edge clears a four-bit phase counter. The start bit is checked again halfway through its bit time. If the line is still low there, the counter is cleared again. From then on the line is sampled each time the counter wraps, which falls near the centre of every data bit and of the stop bit.

The finished byte moves from the shift register into a separate holding register and sets a full flag. The shift register is then free, so a new character can be received at once while the consumer still has the previous byte to read. Pulsing `rd_strobe` consumes the held byte.

Top module: `serial_byte_receiver`

## Requirements
- R1: After reset, `held_byte` is 0x00 and `byte_full`, `frame_err` and `overrun_err` are all 0.
- R2: Reception starts only on a 1-to-0 change of the synchronized line, observed between two consecutive sample enables. A line that stays at 1 delivers nothing.
- R3: A low pulse that has ended before the eighth sample enable after the falling edge is rejected as a false start. No byte is delivered, and a valid character that follows is received correctly.
- R4: Data bits are sampled once every 16 sample enables, starting from the confirmed start-bit centre. They are assembled least significant bit first, so the first data bit on the line appears in `held_byte[0]`.
- R5: If the stop-bit sample is 0, the byte is still delivered and `frame_err` goes to 1. If the stop-bit sample is 1, `frame_err` goes to 0. The flag always describes the most recently delivered byte.
- R6: Each delivered byte is loaded into `held_byte` and sets `byte_full`. A one-cycle `rd_strobe` with no delivery in the same cycle clears `byte_full`.
- R7: If a byte is delivered while `byte_full` is 1 and `rd_strobe` is 0, `overrun_err` goes to 1 and the new byte replaces the old one. `rd_strobe` clears `overrun_err`.
- R8: A character whose start bit follows the previous character's single stop bit directly, with no idle time, is received correctly.
- R9: Characters framed with two stop bits are received the same as characters with one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Consume the held byte; clears full and overrun |
| held_byte | output | 8 | Holding register contents |
| byte_full | output | 1 | Holding register contains an unread byte |
| frame_err | output | 1 | Last delivered byte had a low stop-bit sample |
| overrun_err | output | 1 | An unread byte was overwritten |

## Verification
The assertions assume that `rd_strobe` is a single-cycle pulse. They also assume that `sample_tick` is a one-cycle pulse that never runs faster than every second clock, so at most one byte can be delivered in any cycle.

The stimulus drives `sample_tick` once every four clocks. It changes `rx_line` and `rd_strobe` only on falling clock edges. It holds each serial bit for exactly sixteen sample periods, which keeps the bit rate matched and keeps every centre sample well clear of a bit boundary.

// File: rtl/rx_pkg.sv
// Shared types for the oversampling serial receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rx_pkg;

    // Reception phase of the bit engine.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_t;

endpackage

// File: rtl/rx_line_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// What it does: passes rx_in through a chain of flops into the clk domain.
// Assumes: SYNC_STAGES >= 2; the chain resets to 1 (the idle level), so reset
// can never look like a start edge.
module rx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_sync
);

    logic [SYNC_STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= rx_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign rx_sync = chain[SYNC_STAGES-1];

endmodule

// File: rtl/rx_bit_engine.sv
// Oversampling bit engine for the serial receiver.
// What it does: looks for a falling edge between sample enables, confirms the
// start bit at half a bit time, then samples each data bit and the stop bit
// every OVERSAMPLE enables, shifting data in LSB first. It raises a one-cycle
// deliver pulse with the byte and a low-stop flag.
// Assumes: line_s is already synchronized; tick is a one-cycle enable.
module rx_bit_engine
    import rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_s,
    output logic                 deliver,
    output logic [DATA_BITS-1:0] deliver_byte,
    output logic                 deliver_ferr
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_BITS - 1);

    rx_phase_t            phase_q;
    logic [CNT_W-1:0]     os_cnt;
    logic [BIT_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 prev_line;
    logic                 fell;
    logic                 cnt_mid;
    logic                 cnt_wrap;

    // Decode edge and counter milestones.
    always_comb begin
        fell     = prev_line && !line_s;
        cnt_mid  = (os_cnt == MID_LAST);
        cnt_wrap = (os_cnt == FULL_LAST);
    end

    // Reception state machine, phase counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            os_cnt       <= '0;
            bit_idx      <= '0;
            shreg        <= '0;
            prev_line    <= 1'b1;
            deliver      <= 1'b0;
            deliver_ferr <= 1'b0;
        end else begin
            deliver <= 1'b0;
            if (tick) begin
                prev_line <= line_s;
                case (phase_q)
                    PH_IDLE: begin
                        if (fell) begin
                            os_cnt  <= '0;
                            phase_q <= PH_START;
                        end
                    end
                    PH_START: begin
                        if (cnt_mid) begin
                            os_cnt <= '0;
                            if (!line_s) begin
                                bit_idx <= '0;
                                phase_q <= PH_DATA;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt_wrap) begin
                            os_cnt <= '0;
                            shreg  <= {line_s, shreg[DATA_BITS-1:1]};
                            if (bit_idx == BIT_LAST) begin
                                phase_q <= PH_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (cnt_wrap) begin
                            os_cnt       <= '0;
                            deliver      <= 1'b1;
                            deliver_ferr <= !line_s;
                            phase_q      <= PH_IDLE;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign deliver_byte = shreg;

endmodule

// File: rtl/rx_hold_buffer.sv
// Holding register behind the receive shift register.
// What it does: captures each delivered byte with its framing flag, keeps a
// full flag, and flags overrun when an unread byte is overwritten.
// Assumes: rd_strobe is a one-cycle pulse; a read in the same cycle as a
// delivery consumes the old byte, so no overrun is raised.
module rx_hold_buffer #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 deliver,
    input  logic [DATA_BITS-1:0] deliver_byte,
    input  logic                 deliver_ferr,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] held_byte,
    output logic                 byte_full,
    output logic                 frame_err,
    output logic                 overrun_err
);

    // Load, consume and flag bookkeeping for the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_byte   <= '0;
            byte_full   <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else if (deliver) begin
            held_byte <= deliver_byte;
            byte_full <= 1'b1;
            frame_err <= deliver_ferr;
            if (byte_full && !rd_strobe) begin
                overrun_err <= 1'b1;
            end else if (rd_strobe) begin
                overrun_err <= 1'b0;
            end
        end else if (rd_strobe) begin
            byte_full   <= 1'b0;
            overrun_err <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_byte_receiver.sv
// Top of the double-buffered oversampling serial receiver.
// What it does: synchronizes the line, recovers start-stop characters with a
// 16x sample enable and buffers each byte in a holding register.
// Assumes: sample_tick is a one-cycle pulse at OVERSAMPLE times the bit rate.
module serial_byte_receiver #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 rx_line,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] held_byte,
    output logic                 byte_full,
    output logic                 frame_err,
    output logic                 overrun_err
);

    logic                 line_s;
    logic                 deliver;
    logic [DATA_BITS-1:0] deliver_byte;
    logic                 deliver_ferr;

    rx_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_in  (rx_line),
        .rx_sync(line_s)
    );

    rx_bit_engine #(
        .DATA_BITS (DATA_BITS),
        .OVERSAMPLE(OVERSAMPLE)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sample_tick),
        .line_s      (line_s),
        .deliver     (deliver),
        .deliver_byte(deliver_byte),
        .deliver_ferr(deliver_ferr)
    );

    rx_hold_buffer #(
        .DATA_BITS(DATA_BITS)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .deliver     (deliver),
        .deliver_byte(deliver_byte),
        .deliver_ferr(deliver_ferr),
        .rd_strobe   (rd_strobe),
        .held_byte   (held_byte),
        .byte_full   (byte_full),
        .frame_err   (frame_err),
        .overrun_err (overrun_err)
    );

endmodule

// File: rtl/rx_checker.sv
// Assertion checker for serial_byte_receiver, attached with bind.
// Assumes: rd_strobe is a one-cycle pulse.
module rx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_strobe,
    input logic                 deliver,
    input logic                 deliver_ferr,
    input logic [DATA_BITS-1:0] deliver_byte,
    input logic [DATA_BITS-1:0] held_byte,
    input logic                 byte_full,
    input logic                 frame_err,
    input logic                 overrun_err
);

    // R6: the full flag rises only after a delivery.
    a_r6_full_needs_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_full) |-> $past(deliver));

    // R6: a read with no delivery empties the holding register.
    a_r6_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !deliver) |=> !byte_full);

    // R6: a delivery loads the delivered byte.
    a_r6_byte_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> (held_byte == $past(deliver_byte)));

    // R6: without a delivery the held byte does not change.
    a_r6_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver |=> $stable(held_byte));

    // R5: the framing flag follows the stop sample of the delivered byte.
    a_r5_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> (frame_err == $past(deliver_ferr)));

    // R7: overrun rises only when an unread byte is overwritten.
    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(deliver && byte_full && !rd_strobe));

    // R7: a read clears overrun.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !overrun_err);

    // R7: overrun is only raised with a byte present.
    a_r7_overrun_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |-> byte_full);

endmodule

bind serial_byte_receiver rx_checker #(
    .DATA_BITS(DATA_BITS)
) u_rx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .deliver     (deliver),
    .deliver_ferr(deliver_ferr),
    .deliver_byte(deliver_byte),
    .held_byte   (held_byte),
    .byte_full   (byte_full),
    .frame_err   (frame_err),
    .overrun_err (overrun_err)
);

// File: tb/serial_byte_receiver_bench.sv
// Directed bench for serial_byte_receiver: one task per scenario.
module serial_byte_receiver_bench;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] held_byte;
    logic       byte_full;
    logic       frame_err;
    logic       overrun_err;

    int n_checks = 0;
    int n_fails  = 0;

    serial_byte_receiver u_serial_byte_receiver (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_tick(sample_tick),
        .rx_line    (rx_line),
        .rd_strobe  (rd_strobe),
        .held_byte  (held_byte),
        .byte_full  (byte_full),
        .frame_err  (frame_err),
        .overrun_err(overrun_err)
    );

    always #5 clk = ~clk;

    // Sample enable: one clock in every TICK_DIV.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            sample_tick = (cnt == TICK_DIV - 1);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic stop_val, input int n_stop);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        for (int i = 0; i < n_stop; i++) hold_bit(stop_val);
        rx_line = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 held_byte", {24'd0, held_byte}, 32'h00);
        check("R1 byte_full", {31'd0, byte_full}, 0);
        check("R1 frame_err", {31'd0, frame_err}, 0);
        check("R1 overrun_err", {31'd0, overrun_err}, 0);
        repeat (4 * BIT_CLKS) @(negedge clk);
        check("R2 idle line delivers nothing", {31'd0, byte_full}, 0);
    endtask

    task automatic t_basic();
        send_char(8'hA5, 1'b1, 1);
        check("R4 LSB-first byte", {24'd0, held_byte}, 32'hA5);
        check("R6 full after delivery", {31'd0, byte_full}, 1);
        check("R5 good stop", {31'd0, frame_err}, 0);
        do_read();
        check("R6 read clears full", {31'd0, byte_full}, 0);
        send_char(8'h01, 1'b1, 1);
        check("R4 first bit lands in bit 0", {24'd0, held_byte}, 32'h01);
        do_read();
    endtask

    task automatic t_overrun_back_to_back();
        send_char(8'h3C, 1'b1, 1);
        send_char(8'h81, 1'b1, 1);
        check("R8 back-to-back second byte", {24'd0, held_byte}, 32'h81);
        check("R7 overrun set", {31'd0, overrun_err}, 1);
        check("R7 still full", {31'd0, byte_full}, 1);
        do_read();
        check("R7 read clears overrun", {31'd0, overrun_err}, 0);
        check("R6 empty after read", {31'd0, byte_full}, 0);
    endtask

    task automatic t_framing();
        send_char(8'h5A, 1'b0, 1);
        check("R5 low stop sets frame_err", {31'd0, frame_err}, 1);
        check("R5 byte still delivered", {24'd0, held_byte}, 32'h5A);
        check("R5 full with framing error", {31'd0, byte_full}, 1);
        do_read();
        hold_bit(1'b1);
        hold_bit(1'b1);
        send_char(8'hC3, 1'b1, 1);
        check("R5 good stop clears frame_err", {31'd0, frame_err}, 0);
        check("R5 next byte", {24'd0, held_byte}, 32'hC3);
        do_read();
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R3 glitch delivers nothing", {31'd0, byte_full}, 0);
        send_char(8'h96, 1'b1, 1);
        check("R3 valid byte after glitch", {24'd0, held_byte}, 32'h96);
        do_read();
    endtask

    task automatic t_two_stop();
        send_char(8'h7E, 1'b1, 2);
        check("R9 two stop bits byte", {24'd0, held_byte}, 32'h7E);
        check("R9 two stop bits no frame_err", {31'd0, frame_err}, 0);
        do_read();
        send_char(8'hE7, 1'b1, 2);
        check("R9 second two-stop byte", {24'd0, held_byte}, 32'hE7);
        check("R9 no overrun after read", {31'd0, overrun_err}, 0);
        do_read();
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overrun_back_to_back();
        t_framing();
        t_glitch();
        t_two_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule